// File: doc/BRIEF.md
# Multiprocessor Serial Receiver with Address Filter

This block receives asynchronous serial frames on a single line that idles high and hands each received byte to software through a data register and a receive flag. Two frame formats are supported: a 10-bit frame (start, eight data bits sent least significant bit first, stop) and an 11-bit frame (start, eight data bits, a ninth bit, stop). Bits are timed by a 16x oversampling tick supplied from outside; each bit is sampled at the middle of its period.

For multidrop buses the receiver can filter frames in hardware. With the multiprocessor enable set in the 11-bit format, only frames whose ninth bit is 1 and whose byte matches a programmable slave address under a per-bit mask raise the receive flag. In the 10-bit format the same enable suppresses frames with a bad stop bit. A sticky framing-error flag records any frame whose stop bit was sampled low, and a select input decides whether a shared status bit shows that flag or the frame-format bit. Both flags are cleared only by their software clear pulses.

Top module: `mp_rx_filter`

## Requirements
- R1: With `frameMode`=0 (10-bit frame) the eight data bits, sent least significant first, appear on `rxData` and the sampled stop bit appears on `rxBit9` when the frame is accepted with `mpEnable`=0.
- R2: With `frameMode`=1 (11-bit frame) the bit after the eight data bits is captured into `rxBit9` of an accepted frame.
- R3: With `frameMode`=1 and `mpEnable`=1, a frame whose ninth bit is 0 does not raise `rxFlag` and leaves `rxData` unchanged.
- R4: With `frameMode`=1 and `mpEnable`=1, a frame whose ninth bit is 1 raises `rxFlag` only if `(data ^ slaveAddr) & addrMask` is zero; mask bits of 0 are don't care, so an all-zero mask accepts any byte.
- R5: With `frameMode`=0 and `mpEnable`=1, a frame whose stop bit is sampled low does not raise `rxFlag`.
- R6: `feFlag` is set by any frame whose stop bit is sampled low and stays set until a `feClear` pulse; a new error in the same cycle as the clear wins.
- R7: `rxFlag` is raised at the middle of the stop bit of an accepted frame and stays set until an `rxClear` pulse; while it is set, further frames do not change `rxData` or `rxBit9`.
- R8: While `rxEnable` is 0 no frame is received and `rxFlag` is not raised.
- R9: A falling edge on the line whose level is high again at the middle of the start bit is discarded and does not disturb the next frame.
- R10: `ctrlTopBit` equals `feFlag` when `feMode`=1 and equals `frameMode` when `feMode`=0.
- R11: After reset `rxFlag`, `feFlag`, `rxBit9` and `rxData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxIn | input | 1 | Serial receive line, idle high |
| sampleTick | input | 1 | One-cycle pulse at 16x the bit rate |
| frameMode | input | 1 | 0: 10-bit frame, 1: 11-bit frame |
| rxEnable | input | 1 | Reception enabled while 1 |
| mpEnable | input | 1 | Multiprocessor filtering enable |
| slaveAddr | input | 8 | Slave address to compare |
| addrMask | input | 8 | Per-bit compare enable for the address |
| feMode | input | 1 | Selects what `ctrlTopBit` shows |
| rxClear | input | 1 | Pulse clearing `rxFlag` |
| feClear | input | 1 | Pulse clearing `feFlag` |
| rxData | output | 8 | Last accepted byte |
| rxBit9 | output | 1 | Ninth bit (11-bit) or stop bit (10-bit) of the last accepted frame |
| rxFlag | output | 1 | Receive flag |
| feFlag | output | 1 | Sticky framing-error flag |
| ctrlTopBit | output | 1 | Framing-error flag or frame-format bit |

## Verification
The assertions take for granted that `frameMode`, `mpEnable`, `slaveAddr` and `addrMask` stay still while a frame is in flight, that `sampleTick` is a single-cycle pulse, and that the clears are single-cycle pulses. The stimulus changes configuration only while the line is idle between frames, generates the tick as one cycle in four, and drives every clear as one cycle. Frames are held for exactly sixteen ticks per bit so each sample point falls well inside its bit.

// File: rtl/mp_rx_pkg.sv
package mp_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP,
    ST_WAIT_HIGH
  } rxState_t;

  typedef struct packed {
    logic shiftData;
    logic takeNinth;
    logic frameDone;
  } rxStrobe_t;

endpackage

// File: rtl/mp_rx_ctrl.sv
module mp_rx_ctrl
  import mp_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16,
  parameter int DATA_BITS  = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleTick,
  input  logic      rxEnable,
  input  logic      frameMode,
  input  logic      rxS,
  output rxStrobe_t strb
);

  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rxState_t         state;
  logic [CNT_W-1:0] tickCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             bitEnd;

  assign bitEnd = sampleTick && (tickCnt == LAST_CNT);

  always_comb begin
    strb = '0;
    strb.shiftData = bitEnd && (state == ST_DATA);
    strb.takeNinth = bitEnd && (state == ST_NINTH);
    strb.frameDone = bitEnd && (state == ST_STOP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (!rxEnable) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      bitCnt  <= '0;
    end else if (sampleTick) begin
      case (state)
        ST_IDLE: begin
          tickCnt <= '0;
          if (!rxS) state <= ST_START;
        end
        ST_START: begin
          if (tickCnt == MID_CNT) begin
            tickCnt <= '0;
            bitCnt  <= '0;
            state   <= rxS ? ST_IDLE : ST_DATA;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            if (bitCnt == LAST_BIT) state <= frameMode ? ST_NINTH : ST_STOP;
            else bitCnt <= bitCnt + 1'b1;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_NINTH: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= ST_STOP;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (tickCnt == LAST_CNT) begin
            tickCnt <= '0;
            state   <= rxS ? ST_IDLE : ST_WAIT_HIGH;
          end else begin
            tickCnt <= tickCnt + 1'b1;
          end
        end
        ST_WAIT_HIGH: begin
          tickCnt <= '0;
          if (rxS) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> (state == ST_IDLE)); // R8

  AST_START_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_START && sampleTick && tickCnt == MID_CNT && rxS) |=> (state == ST_IDLE || !rxEnable)); // R9

endmodule

// File: rtl/mp_rx_dpath.sv
module mp_rx_dpath
  import mp_rx_pkg::*;
#(
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  rxStrobe_t            strb,
  input  logic                 frameMode,
  input  logic                 mpEnable,
  input  logic [DATA_BITS-1:0] slaveAddr,
  input  logic [DATA_BITS-1:0] addrMask,
  input  logic                 rxClear,
  input  logic                 feClear,
  output logic                 rxS,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxFlag,
  output logic                 feFlag
);

  logic [DATA_BITS-1:0] shiftReg;
  logic                 ninthReg;
  logic                 addrHit;
  logic                 qualifies;
  logic                 acceptFrame;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= rxIn;
      end
      assign rxS = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxIn};
      end
      assign rxS = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      ninthReg <= 1'b0;
    end else begin
      if (strb.shiftData) shiftReg <= {rxS, shiftReg[DATA_BITS-1:1]};
      if (strb.takeNinth) ninthReg <= rxS;
    end
  end

  assign addrHit = (((shiftReg ^ slaveAddr) & addrMask) == '0);

  always_comb begin
    if (!mpEnable)      qualifies = 1'b1;
    else if (frameMode) qualifies = ninthReg && addrHit;
    else                qualifies = rxS;
  end

  assign acceptFrame = strb.frameDone && qualifies && !rxFlag;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
      rxBit9 <= 1'b0;
      rxFlag <= 1'b0;
    end else if (acceptFrame) begin
      rxData <= shiftReg;
      rxBit9 <= frameMode ? ninthReg : rxS;
      rxFlag <= 1'b1;
    end else if (rxClear) begin
      rxFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        feFlag <= 1'b0;
    else if (strb.frameDone && !rxS)  feFlag <= 1'b1;
    else if (feClear)                 feFlag <= 1'b0;
  end

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (rxFlag && !rxClear) |=> rxFlag); // R7

  AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (!rstN)
    rxFlag |=> ($stable(rxData) && $stable(rxBit9))); // R7

  AST_FE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (feFlag && !feClear) |=> feFlag); // R6

  AST_FE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(feFlag) |-> $past(strb.frameDone)); // R6

  AST_NINTH_ZERO_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && frameMode && mpEnable && !ninthReg && !rxFlag) |=> !rxFlag); // R3

  AST_BAD_STOP_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.frameDone && !frameMode && mpEnable && !rxS && !rxFlag) |=> !rxFlag); // R5

endmodule

// File: rtl/mp_rx_filter.sv
module mp_rx_filter
  import mp_rx_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 rxIn,
  input  logic                 sampleTick,
  input  logic                 frameMode,
  input  logic                 rxEnable,
  input  logic                 mpEnable,
  input  logic [DATA_BITS-1:0] slaveAddr,
  input  logic [DATA_BITS-1:0] addrMask,
  input  logic                 feMode,
  input  logic                 rxClear,
  input  logic                 feClear,
  output logic [DATA_BITS-1:0] rxData,
  output logic                 rxBit9,
  output logic                 rxFlag,
  output logic                 feFlag,
  output logic                 ctrlTopBit
);

  rxStrobe_t strb;
  logic      rxS;

  mp_rx_ctrl #(
    .OVERSAMPLE (OVERSAMPLE),
    .DATA_BITS  (DATA_BITS)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .rxEnable   (rxEnable),
    .frameMode  (frameMode),
    .rxS        (rxS),
    .strb       (strb)
  );

  mp_rx_dpath #(
    .DATA_BITS   (DATA_BITS),
    .SYNC_STAGES (SYNC_STAGES)
  ) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .rxIn      (rxIn),
    .strb      (strb),
    .frameMode (frameMode),
    .mpEnable  (mpEnable),
    .slaveAddr (slaveAddr),
    .addrMask  (addrMask),
    .rxClear   (rxClear),
    .feClear   (feClear),
    .rxS       (rxS),
    .rxData    (rxData),
    .rxBit9    (rxBit9),
    .rxFlag    (rxFlag),
    .feFlag    (feFlag)
  );

  assign ctrlTopBit = feMode ? feFlag : frameMode;

endmodule

// File: tb/test_mp_rx_filter.sv
`timescale 1ns/1ps
module test_mp_rx_filter;

  typedef struct {
    logic       expFlag;
    logic [7:0] expData;
    logic       expBit9;
    logic       expFe;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       sampleTick = 1'b0;
  logic       frameMode = 1'b0;
  logic       rxEnable = 1'b1;
  logic       mpEnable = 1'b0;
  logic [7:0] slaveAddr = 8'h00;
  logic [7:0] addrMask = 8'h00;
  logic       feMode = 1'b0;
  logic       rxClear = 1'b0;
  logic       feClear = 1'b0;
  logic [7:0] rxData;
  logic       rxBit9;
  logic       rxFlag;
  logic       feFlag;
  logic       ctrlTopBit;

  int checks = 0;
  int errors = 0;
  int tickDiv = 0;
  logic finished = 1'b0;

  expItem_t expQ[$];
  logic       mFlag = 1'b0;
  logic [7:0] mData = 8'h00;
  logic       mBit9 = 1'b0;
  logic       mFe = 1'b0;

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickDiv = (tickDiv + 1) % 4;
    sampleTick = (tickDiv == 0);
  end

  mp_rx_filter i_mp_rx_filter (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .sampleTick(sampleTick),
    .frameMode(frameMode), .rxEnable(rxEnable), .mpEnable(mpEnable),
    .slaveAddr(slaveAddr), .addrMask(addrMask), .feMode(feMode),
    .rxClear(rxClear), .feClear(feClear), .rxData(rxData), .rxBit9(rxBit9),
    .rxFlag(rxFlag), .feFlag(feFlag), .ctrlTopBit(ctrlTopBit)
  );

  task automatic check(input logic ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic sendBit(input logic b);
    rxIn = b;
    repeat (64) @(negedge clk);
  endtask

  // Drives one frame, updates the bench model from the requirements, queues the expectation.
  task automatic sendFrame(input logic [7:0] data, input logic ninth, input logic stopBit, input string tag);
    logic qual;
    sendBit(1'b0);
    for (int i = 0; i < 8; i++) sendBit(data[i]);
    if (frameMode) sendBit(ninth);
    sendBit(stopBit);
    rxIn = 1'b1;
    repeat (128) @(negedge clk);
    if (rxEnable) begin
      if (!mpEnable)      qual = 1'b1;
      else if (frameMode) qual = ninth && (((data ^ slaveAddr) & addrMask) == 8'h00);
      else                qual = stopBit;
      if (qual && !mFlag) begin
        mFlag = 1'b1;
        mData = data;
        mBit9 = frameMode ? ninth : stopBit;
      end
      if (!stopBit) mFe = 1'b1;
    end
    expQ.push_back('{mFlag, mData, mBit9, mFe, tag});
    repeat (2) @(negedge clk);
  endtask

  task automatic clearRx();
    rxClear = 1'b1;
    @(negedge clk);
    rxClear = 1'b0;
    mFlag = 1'b0;
    @(negedge clk);
  endtask

  task automatic clearFe();
    feClear = 1'b1;
    @(negedge clk);
    feClear = 1'b0;
    mFe = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pops expectations and compares against the ports.
  initial begin
    forever begin
      @(negedge clk);
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        check(rxFlag == e.expFlag, {e.tag, " rxFlag"}, rxFlag, e.expFlag);
        check(feFlag == e.expFe, {e.tag, " feFlag R6"}, feFlag, e.expFe);
        if (e.expFlag) begin
          check(rxData == e.expData, {e.tag, " rxData"}, rxData, e.expData);
          check(rxBit9 == e.expBit9, {e.tag, " rxBit9"}, rxBit9, e.expBit9);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(negedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(rxFlag == 1'b0, "R11 rxFlag", rxFlag, 0);
    check(feFlag == 1'b0, "R11 feFlag", feFlag, 0);
    check(rxData == 8'h00, "R11 rxData", rxData, 0);
    check(rxBit9 == 1'b0, "R11 rxBit9", rxBit9, 0);

    // R1 10-bit frame, stop reported in rxBit9
    sendFrame(8'hA5, 1'b0, 1'b1, "R1 10-bit good");
    clearRx();
    // R6 framing error, frame still accepted without filtering
    sendFrame(8'h3C, 1'b0, 1'b0, "R6 10-bit bad stop");
    // R10 status bit selection
    feMode = 1'b1; @(negedge clk);
    check(ctrlTopBit == 1'b1, "R10 feMode=1 shows fe", ctrlTopBit, 1);
    feMode = 1'b0; @(negedge clk);
    check(ctrlTopBit == 1'b0, "R10 feMode=0 shows frameMode", ctrlTopBit, 0);
    clearRx();
    // R6 sticky across a good frame and an rxClear
    sendFrame(8'h0F, 1'b0, 1'b1, "R6 fe sticky");
    clearRx();
    clearFe();
    sendFrame(8'h10, 1'b0, 1'b1, "R6 after feClear");
    clearRx();

    // R5 10-bit with filtering, bad stop dropped
    mpEnable = 1'b1;
    sendFrame(8'h77, 1'b0, 1'b0, "R5 bad stop dropped");
    clearFe();
    sendFrame(8'h78, 1'b0, 1'b1, "R5 good stop kept");
    clearRx();

    // R2 11-bit frame
    frameMode = 1'b1; mpEnable = 1'b0;
    feMode = 1'b0; @(negedge clk);
    check(ctrlTopBit == 1'b1, "R10 feMode=0 frameMode=1", ctrlTopBit, 1);
    sendFrame(8'h3C, 1'b0, 1'b1, "R2 ninth=0");
    clearRx();
    sendFrame(8'hC3, 1'b1, 1'b1, "R2 ninth=1");
    clearRx();

    // R3 / R4 filtering
    mpEnable = 1'b1; slaveAddr = 8'h5A; addrMask = 8'hFF;
    sendFrame(8'h5A, 1'b0, 1'b1, "R3 ninth=0 dropped");
    sendFrame(8'h5A, 1'b1, 1'b1, "R4 exact match");
    clearRx();
    sendFrame(8'h5B, 1'b1, 1'b1, "R4 mismatch dropped");
    slaveAddr = 8'h50; addrMask = 8'hF0;
    sendFrame(8'h5F, 1'b1, 1'b1, "R4 masked match");
    clearRx();
    sendFrame(8'h6F, 1'b1, 1'b1, "R4 masked mismatch");
    addrMask = 8'h00;
    sendFrame(8'h99, 1'b1, 1'b1, "R4 zero mask any");
    // R7 no overwrite while flag set
    mpEnable = 1'b0;
    sendFrame(8'h11, 1'b0, 1'b1, "R7 no overwrite");
    clearRx();

    // R8 receive disabled
    rxEnable = 1'b0;
    sendFrame(8'h42, 1'b1, 1'b1, "R8 disabled");
    rxEnable = 1'b1;
    repeat (8) @(negedge clk);

    // R9 glitch start rejected, next frame intact
    rxIn = 1'b0;
    repeat (12) @(negedge clk);
    rxIn = 1'b1;
    repeat (160) @(negedge clk);
    expQ.push_back('{mFlag, mData, mBit9, mFe, "R9 glitch ignored"});
    repeat (2) @(negedge clk);
    sendFrame(8'hE7, 1'b0, 1'b1, "R9 frame after glitch");
    clearRx();

    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule